// File: doc/BRIEF.md
# Automatic Serial Flow Control Unit

This block sits next to a UART. It decides two things: when the local transmitter may start a new character, and when the remote sender has to pause. It watches the receive FIFO fill level against two programmable thresholds, a higher one that throttles and a lower one that releases. The gap between them gives hysteresis. The throttle state drives the RTS pin when hardware flow control is on. When software flow control is on, the same state raises one-shot requests to insert an Xoff or Xon character into the outgoing stream.

On the transmit side, the block combines the incoming CTS pin (hardware mode) with a halt state set by received Xoff characters (software mode) into a single gate. The gate only changes between characters, so a character already being shifted out always completes. An optional mode lets any received character release an Xoff halt. In software mode, received characters that match the programmed Xon or Xoff value are flagged as consumed, so they are not written to the receive FIFO. A threshold setting with the resume level at or above the halt level turns off all flow control.

Top module: `serial_flow_ctrl`

## Requirements
- R1: After reset, `rts_n` is 0, `tx_gate` is 1, and `xon_req` and `xoff_req` are 0.
- R2: With hardware mode on and a valid configuration, `rts_n` goes to 1 in the cycle after `rx_level` is at or above `halt_lvl`. It returns to 0 in the cycle after `rx_level` is at or below `resume_lvl`, and it holds its value between those two levels.
- R3: With hardware mode on, `cts_n` = 1 makes `tx_gate` fall one cycle later, and `cts_n` = 0 lets it rise one cycle later, as long as `tx_busy` is 0.
- R4: While `tx_busy` is 1, `tx_gate` keeps its value. A pending change takes effect in the cycle after `tx_busy` returns to 0.
- R5: With software mode on, a received byte (`rx_stb` = 1) equal to `xoff_code` sets the Xoff halt, and `tx_gate` falls two cycles later. A received byte equal to `xon_code` clears the halt. If both codes are equal, Xoff takes precedence.
- R6: With `any_resume` = 1 and software mode on, any received byte other than `xoff_code` clears the Xoff halt.
- R7: With software mode on, `xoff_req` pulses for exactly one cycle when the throttle state is entered, and `xon_req` pulses for exactly one cycle when it is left. The two are never high together.
- R8: When `resume_lvl` >= `halt_lvl`, both modes are off. `rts_n` stays 0, no requests are raised, received codes are kept, and Xoff has no effect on `tx_gate`.
- R9: With software mode on, `rx_keep` is 0 for a strobed byte that matches `xon_code` or `xoff_code`. Otherwise `rx_keep` equals `rx_stb`, in the same cycle.
- R10: The two modes are independent. With `hw_en` = 0, `rts_n` stays 0 and `cts_n` is ignored. With `sw_en` = 0, no requests are raised and received codes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Enable RTS/CTS flow control |
| sw_en | input | 1 | Enable Xon/Xoff flow control |
| any_resume | input | 1 | Any received byte releases an Xoff halt |
| halt_lvl | input | LW | Receive level that starts throttling |
| resume_lvl | input | LW | Receive level that ends throttling |
| xon_code | input | CW | Xon character value |
| xoff_code | input | CW | Xoff character value |
| rx_level | input | LW | Receive FIFO fill level |
| rx_stb | input | 1 | One received byte is present this cycle |
| rx_byte | input | CW | Value of the received byte |
| cts_n | input | 1 | Incoming clear-to-send, active low, already synchronised |
| tx_busy | input | 1 | Serializer is shifting a character |
| rts_n | output | 1 | Outgoing request-to-send, active low |
| tx_gate | output | 1 | Serializer may start a new character |
| xon_req | output | 1 | One-cycle request to send Xon |
| xoff_req | output | 1 | One-cycle request to send Xoff |
| rx_keep | output | 1 | Write the strobed byte into the receive FIFO |

## Verification
Two events can land in the same cycle. The receive level can cross a threshold, raising a send request, in the same cycle that an Xon or Xoff character arrives and changes the transmit halt. A CTS change can also arrive during the last cycle of a busy character. The bench provokes both on purpose: it strobes the Xon code in the same cycle the level reaches the halt threshold, and it toggles `cts_n` while `tx_busy` drops. A behavioural reference model, updated every clock, judges every output. It checks that the Xoff request and the transmit release both occur, each with its own latency, and that neither masks the other.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef struct packed {
    logic hw;
    logic sw;
  } sfc_mode_t;

  // thresholds form a usable window only when resume sits strictly below halt
  function automatic logic window_ok(input int unsigned halt, input int unsigned resume);
    return resume < halt;
  endfunction

  // next throttle state from the receive fill level
  function automatic logic throttle_next(input logic cur, input int unsigned lvl,
                                         input int unsigned halt, input int unsigned resume);
    if (lvl >= halt) return 1'b1;
    if (lvl <= resume) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/sfc_char_match.sv
module sfc_char_match #(
  parameter int CW = 8
) (
  input  logic          sw_on,
  input  logic          rx_stb,
  input  logic [CW-1:0] rx_byte,
  input  logic [CW-1:0] xon_code,
  input  logic [CW-1:0] xoff_code,
  output logic          hit_xon,
  output logic          hit_xoff,
  output logic          hit_other,
  output logic          keep
);
  logic eq_on, eq_off;

  always_comb begin
    eq_off    = (rx_byte == xoff_code);
    eq_on     = (rx_byte == xon_code);
    hit_xoff  = sw_on & rx_stb & eq_off;
    hit_xon   = sw_on & rx_stb & eq_on & ~eq_off;
    hit_other = sw_on & rx_stb & ~eq_on & ~eq_off;
    keep      = rx_stb & ~hit_xon & ~hit_xoff;
  end
endmodule

// File: rtl/sfc_rx_throttle.sv
module sfc_rx_throttle
  import sfc_pkg::*;
#(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sfc_mode_t     mode,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] halt_lvl,
  input  logic [LW-1:0] resume_lvl,
  output logic          throttle,
  output logic          xon_req,
  output logic          xoff_req
);
  logic any_on, thr_nxt, enter_ev, leave_ev;

  always_comb begin
    any_on   = mode.hw | mode.sw;
    thr_nxt  = any_on ? throttle_next(throttle, 32'(level), 32'(halt_lvl), 32'(resume_lvl))
                      : 1'b0;
    enter_ev = mode.sw & ~throttle & thr_nxt;
    leave_ev = mode.sw & throttle & ~thr_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      throttle <= 1'b0;
      xon_req  <= 1'b0;
      xoff_req <= 1'b0;
    end else begin
      throttle <= thr_nxt;
      xon_req  <= leave_ev;
      xoff_req <= enter_ev;
    end
  end

  // R7
  no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xon_req && xoff_req));
  // R7
  xoff_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_req |-> throttle && !$past(throttle));
  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode.hw || mode.sw) |=> !throttle);
endmodule

// File: rtl/sfc_tx_gate.sv
module sfc_tx_gate
  import sfc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sfc_mode_t mode,
  input  logic      any_resume,
  input  logic      cts_n,
  input  logic      tx_busy,
  input  logic      hit_xon,
  input  logic      hit_xoff,
  input  logic      hit_other,
  output logic      tx_gate,
  output logic      xoff_hold
);
  logic hold_nxt, stop_want;

  always_comb begin
    hold_nxt = xoff_hold;
    if (!mode.sw)                       hold_nxt = 1'b0;
    else if (hit_xoff)                  hold_nxt = 1'b1;
    else if (hit_xon)                   hold_nxt = 1'b0;
    else if (hit_other && any_resume)   hold_nxt = 1'b0;
    stop_want = (mode.hw & cts_n) | xoff_hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xoff_hold <= 1'b0;
      tx_gate   <= 1'b1;
    end else begin
      xoff_hold <= hold_nxt;
      if (!tx_busy) tx_gate <= ~stop_want;
    end
  end

  // R4
  gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> $stable(tx_gate));
  // R5
  xoff_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_xoff |=> xoff_hold);
endmodule

// File: rtl/serial_flow_ctrl.sv
module serial_flow_ctrl
  import sfc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_en,
  input  logic          sw_en,
  input  logic          any_resume,
  input  logic [LW-1:0] halt_lvl,
  input  logic [LW-1:0] resume_lvl,
  input  logic [CW-1:0] xon_code,
  input  logic [CW-1:0] xoff_code,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_stb,
  input  logic [CW-1:0] rx_byte,
  input  logic          cts_n,
  input  logic          tx_busy,
  output logic          rts_n,
  output logic          tx_gate,
  output logic          xon_req,
  output logic          xoff_req,
  output logic          rx_keep
);
  sfc_mode_t mode;
  logic cfg_ok, throttle, xoff_hold;
  logic hit_xon, hit_xoff, hit_other;

  always_comb begin
    cfg_ok  = window_ok(32'(halt_lvl), 32'(resume_lvl));
    mode.hw = hw_en & cfg_ok;
    mode.sw = sw_en & cfg_ok;
    rts_n   = mode.hw & throttle;
  end

  sfc_char_match #(.CW(CW)) u_match (
    .sw_on(mode.sw), .rx_stb(rx_stb), .rx_byte(rx_byte),
    .xon_code(xon_code), .xoff_code(xoff_code),
    .hit_xon(hit_xon), .hit_xoff(hit_xoff), .hit_other(hit_other), .keep(rx_keep)
  );

  sfc_rx_throttle #(.LW(LW)) u_thr (
    .clk(clk), .rst_n(rst_n), .mode(mode), .level(rx_level),
    .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
    .throttle(throttle), .xon_req(xon_req), .xoff_req(xoff_req)
  );

  sfc_tx_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode(mode), .any_resume(any_resume),
    .cts_n(cts_n), .tx_busy(tx_busy),
    .hit_xon(hit_xon), .hit_xoff(hit_xoff), .hit_other(hit_other),
    .tx_gate(tx_gate), .xoff_hold(xoff_hold)
  );

  // R9
  keep_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_keep |-> rx_stb);
  // R10
  rts_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_en |-> !rts_n);
endmodule

// File: tb/serial_flow_ctrl_tb.sv
module serial_flow_ctrl_tb;
  localparam int LW = 7;
  logic clk = 0, rst_n = 0;
  logic hw_en = 0, sw_en = 0, any_resume = 0;
  logic [LW-1:0] halt_lvl = 10, resume_lvl = 4, rx_level = 0;
  logic [7:0] xon_code = 8'h11, xoff_code = 8'h13, rx_byte = 0;
  logic rx_stb = 0, cts_n = 0, tx_busy = 0;
  logic rts_n, tx_gate, xon_req, xoff_req, rx_keep;

  int n_run = 0, n_fail = 0, cyc = 0;
  string phase = "R1 reset";
  // reference state
  int m_thr = 0, m_hold = 0, m_gate = 1, m_on = 0, m_off = 0;

  always #4 clk = ~clk;

  serial_flow_ctrl u_dut (.*);

  function automatic int hwv(); return (hw_en && resume_lvl < halt_lvl) ? 1 : 0; endfunction
  function automatic int swv(); return (sw_en && resume_lvl < halt_lvl) ? 1 : 0; endfunction

  always @(posedge clk) begin
    int thr_new, hold_new;
    cyc++;
    if (!rst_n) begin
      m_thr = 0; m_hold = 0; m_gate = 1; m_on = 0; m_off = 0;
    end else begin
      thr_new = m_thr;
      if (hwv() == 0 && swv() == 0) thr_new = 0;
      else if (int'(rx_level) >= int'(halt_lvl)) thr_new = 1;
      else if (int'(rx_level) <= int'(resume_lvl)) thr_new = 0;
      m_off = (swv() == 1 && m_thr == 0 && thr_new == 1) ? 1 : 0;
      m_on  = (swv() == 1 && m_thr == 1 && thr_new == 0) ? 1 : 0;
      hold_new = m_hold;
      if (swv() == 0) hold_new = 0;
      else if (rx_stb) begin
        if (rx_byte == xoff_code) hold_new = 1;
        else if (rx_byte == xon_code || any_resume) hold_new = 0;
      end
      if (!tx_busy) m_gate = ((hwv() == 1 && cts_n) || m_hold == 1) ? 0 : 1;
      m_hold = hold_new;
      m_thr = thr_new;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] cycle %0d: actual %0d expected %0d", tag, phase, cyc, act, exp);
    end
  endtask

  task automatic compare();
    int keep_exp;
    keep_exp = (rx_stb && !(swv() == 1 && (rx_byte == xon_code || rx_byte == xoff_code))) ? 1 : 0;
    chk("R2 rts_n", int'(rts_n), (hwv() == 1 && m_thr == 1) ? 1 : 0);
    chk("R3/R4/R5 tx_gate", int'(tx_gate), m_gate);
    chk("R7 xon_req", int'(xon_req), m_on);
    chk("R7 xoff_req", int'(xoff_req), m_off);
    chk("R9 rx_keep", int'(rx_keep), keep_exp);
  endtask

  // one cycle: check current outputs, then drive next inputs
  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      rx_stb = 0;
    end
  endtask

  task automatic rx_char(logic [7:0] b);
    @(negedge clk); compare();
    rx_stb = 1; rx_byte = b;
    step(1);
  endtask

  task automatic ramp(int lo, int hi);
    if (lo <= hi) for (int v = lo; v <= hi; v++) begin rx_level = LW'(v); step(1); end
    else for (int v = lo; v >= hi; v--) begin rx_level = LW'(v); step(1); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    chk("R1 rts_n", int'(rts_n), 0);
    chk("R1 tx_gate", int'(tx_gate), 1);
    chk("R1 reqs", int'(xon_req) + int'(xoff_req), 0);

    phase = "R2 hw hysteresis"; hw_en = 1;
    ramp(0, 12); ramp(12, 6); ramp(7, 9); ramp(9, 2);

    phase = "R3 cts"; cts_n = 1; step(3); cts_n = 0; step(3);
    phase = "R4 busy freeze"; tx_busy = 1; cts_n = 1; step(4); tx_busy = 0; step(2);
    cts_n = 0; tx_busy = 1; step(2); tx_busy = 0; step(2);

    phase = "R10 hw only no requests"; ramp(0, 11); rx_char(8'h13); ramp(11, 0);

    phase = "R7 sw requests"; hw_en = 0; sw_en = 1; cts_n = 1;
    ramp(0, 12); step(2); ramp(12, 3); step(2);
    phase = "R5 xoff xon"; rx_char(8'h13); step(3); rx_char(8'h41); step(2);
    rx_char(8'h11); step(3);
    phase = "R5 equal codes"; xon_code = 8'h13; rx_char(8'h13); step(2); xon_code = 8'h11;
    rx_char(8'h11); step(2);
    phase = "R6 any resume"; any_resume = 1; rx_char(8'h13); step(2); rx_char(8'h55); step(3);
    any_resume = 0;

    phase = "R7 same-cycle crossing and xon";
    rx_char(8'h13); step(1);
    @(negedge clk); compare(); rx_level = 10; rx_stb = 1; rx_byte = 8'h11;
    step(3); ramp(9, 4); step(2);
    phase = "R4 cts edge as busy drops"; hw_en = 1; cts_n = 0; tx_busy = 1; step(2);
    @(negedge clk); compare(); tx_busy = 0; cts_n = 1; step(2); cts_n = 0; step(2);

    phase = "R8 bad config"; resume_lvl = 10; ramp(0, 14); rx_char(8'h13); step(2);
    rx_char(8'h11); cts_n = 1; step(2); cts_n = 0; ramp(14, 0);
    resume_lvl = 12; step(1); resume_lvl = 4;

    phase = "R10 sw only rts quiet"; hw_en = 0; cts_n = 1; ramp(0, 12); ramp(12, 0);
    cts_n = 0; step(3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule